// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, for each incoming frame, whether the frame is kept or dropped. The MAC presents the destination address one byte per cycle, starting with a start-of-frame strobe. One cycle after the sixth byte, the filter gives a single-cycle valid pulse with an accept or reject flag.

The decision depends on two things. The first is the class of the destination: broadcast, multicast or unicast. The second is a mode word with a global enable and four accept classes. Software loads the station address indirectly. It first writes a byte pointer, then writes a 16-bit data word into the slot that the pointer selects. The same pointer/data pair reads the address back. Hash-based multicast filtering, wake-up pattern matching and frame storage are not part of the block.

Top module: `dest_addr_filter`

## Requirements
- R1: Register select 0 is the mode word. Bit 31 enables the filter. Bit 30 accepts every broadcast frame. Bit 29 accepts every multicast frame. Bit 28 accepts every unicast frame. Bit 27 accepts a destination equal to the station address. The mode word resets to zero, reads back as written, and may be written while the filter is disabled.
- R2: Register select 1 is the byte pointer, and register select 2 is the data port. Pointer values 0, 2 and 4 select station address bytes 0–1, 2–3 and 4–5. In a data word, the lower-numbered byte sits in bits 7:0 and the next byte in bits 15:8. A read through the data port returns the same layout, with bits 31:16 zero.
- R3: While the pointer holds any value other than 0, 2 or 4, a data write changes no station byte, and a data read returns zero.
- R4: While mode bit 31 is 0, every frame is rejected.
- R5: A destination of six 0xFF bytes is broadcast. With the filter enabled, it is accepted when bit 30 is set.
- R6: A destination that is not broadcast and whose first byte has bit 0 set is multicast. With the filter enabled, it is accepted when bit 29 is set.
- R7: Every other destination is unicast. With the filter enabled, it is accepted when bit 28 is set.
- R8: With the filter enabled and bit 27 set, a destination equal to the station address (byte 0 first on the wire) is accepted, whatever its class. An enabled filter with only bits 30 and 27 set accepts broadcast and station frames and rejects all other multicast frames.
- R9: The result valid pulse comes exactly one cycle after the sixth destination byte and lasts one cycle. The accept output is low whenever valid is low.
- R10: A start-of-frame strobe restarts the comparison, and the byte presented with it is byte 0. Bytes after the sixth, and bytes before the first start-of-frame after reset, produce no result.
- R11: After reset, the station address reads back as all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 pointer, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_sel |
| sof | input | 1 | Start of frame; the byte presented with it is byte 0 |
| byte_vld | input | 1 | Destination byte valid |
| byte_data | input | 8 | Destination address byte |
| res_vld | output | 1 | Decision valid pulse |
| res_accept | output | 1 | Frame accepted (meaningful while res_vld is high) |

## Verification
Register reads are combinational. The bench sets the select in the middle of a cycle and samples the data one nanosecond later. Register writes take effect at the next rising edge, and the bench reads them back only after that edge.

For a frame, the sixth byte is driven at a falling edge and captured at the next rising edge. The bench samples the result at the falling edge that follows, which is exactly one register stage later. It also confirms that valid is low one cycle before and one cycle after that point. The sweep crosses all 32 combinations of the five mode bits with destinations of every class and with the station address, and each expected flag is derived from the class rules.

// File: rtl/daf_pkg.sv
package daf_pkg;
   localparam int MODE_EN_BIT = 31;
   localparam int MODE_BC_BIT = 30;
   localparam int MODE_MC_BIT = 29;
   localparam int MODE_UC_BIT = 28;
   localparam int MODE_PM_BIT = 27;

   typedef enum logic [1:0] {
      RSEL_MODE = 2'd0,
      RSEL_PTR  = 2'd1,
      RSEL_DATA = 2'd2,
      RSEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/daf_regs.sv
module daf_regs #(
   parameter int ADDR_BYTES = 6,
   parameter int SLOT_BYTES = 2,
   parameter int DATA_W     = 32,
   parameter int PTR_W      = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic [1:0]              reg_sel,
   input  logic [DATA_W-1:0]       reg_wdata,
   output logic [DATA_W-1:0]       reg_rdata,
   output logic [DATA_W-1:0]       mode_q,
   output logic [PTR_W-1:0]        ptr_q,
   output logic [ADDR_BYTES*8-1:0] station_q
);
   import daf_pkg::*;
   localparam int NSLOT  = ADDR_BYTES / SLOT_BYTES;
   localparam int SLOT_W = SLOT_BYTES * 8;

   logic [SLOT_W-1:0] slot_rd [NSLOT];
   logic [NSLOT-1:0]  slot_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         ptr_q  <= '0;
      end else if (reg_wr) begin
         if (reg_sel == RSEL_MODE) mode_q <= reg_wdata;
         if (reg_sel == RSEL_PTR)  ptr_q  <= reg_wdata[PTR_W-1:0];
      end
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign slot_hit[s] = (ptr_q == PTR_W'(s * SLOT_BYTES));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            station_q[s*SLOT_W +: SLOT_W] <= '0;
         else if (reg_wr && reg_sel == RSEL_DATA && slot_hit[s])
            station_q[s*SLOT_W +: SLOT_W] <= reg_wdata[SLOT_W-1:0];
      end
      assign slot_rd[s] = slot_hit[s] ? station_q[s*SLOT_W +: SLOT_W] : '0;
   end

   always_comb begin
      logic [SLOT_W-1:0] data_rd;
      data_rd = '0;
      for (int s = 0; s < NSLOT; s++) data_rd |= slot_rd[s];
      unique case (reg_sel)
         RSEL_MODE: reg_rdata = mode_q;
         RSEL_PTR:  reg_rdata = DATA_W'(ptr_q);
         RSEL_DATA: reg_rdata = DATA_W'(data_rd);
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/daf_cmp.sv
module daf_cmp #(
   parameter int ADDR_BYTES = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sof,
   input  logic                    byte_vld,
   input  logic [7:0]              byte_data,
   input  logic [ADDR_BYTES*8-1:0] station,
   output logic                    last,
   output logic                    eq_n,
   output logic                    ones_n,
   output logic                    grp_n
);
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] IDLE = CNT_W'(ADDR_BYTES);

   logic [CNT_W-1:0] cnt_q, idx;
   logic             eq_q, ones_q, grp_q, active;
   logic [7:0]       ref_byte;

   always_comb begin
      idx      = sof ? '0 : cnt_q;
      active   = byte_vld && (idx < IDLE);
      ref_byte = '0;
      for (int b = 0; b < ADDR_BYTES; b++)
         if (idx == CNT_W'(b)) ref_byte = station[b*8 +: 8];
      eq_n   = ((idx == '0) ? 1'b1 : eq_q)   && (byte_data == ref_byte);
      ones_n = ((idx == '0) ? 1'b1 : ones_q) && (byte_data == 8'hFF);
      grp_n  =  (idx == '0) ? byte_data[0] : grp_q;
      last   = active && (idx == IDLE - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= IDLE;
         eq_q   <= 1'b0;
         ones_q <= 1'b0;
         grp_q  <= 1'b0;
      end else if (active) begin
         cnt_q  <= idx + 1'b1;
         eq_q   <= eq_n;
         ones_q <= ones_n;
         grp_q  <= grp_n;
      end else if (sof) begin
         cnt_q  <= '0;
      end
   end
endmodule

// File: rtl/daf_decide.sv
module daf_decide #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              last,
   input  logic              eq,
   input  logic              ones,
   input  logic              grp,
   input  logic [DATA_W-1:0] mode,
   output logic              res_vld,
   output logic              res_accept
);
   import daf_pkg::*;
   logic is_bc, is_mc, is_uc, acc_c;

   always_comb begin
      is_bc = ones;
      is_mc = grp && !ones;
      is_uc = !grp;
      acc_c = mode[MODE_EN_BIT] &&
              ((is_bc && mode[MODE_BC_BIT]) || (is_mc && mode[MODE_MC_BIT]) ||
               (is_uc && mode[MODE_UC_BIT]) || (eq && mode[MODE_PM_BIT]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vld    <= 1'b0;
         res_accept <= 1'b0;
      end else begin
         res_vld    <= last;
         res_accept <= last && acc_c;
      end
   end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
   parameter int ADDR_BYTES = 6,
   parameter int SLOT_BYTES = 2,
   parameter int DATA_W     = 32,
   parameter int PTR_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              sof,
   input  logic              byte_vld,
   input  logic [7:0]        byte_data,
   output logic              res_vld,
   output logic              res_accept
);
   if (ADDR_BYTES % SLOT_BYTES != 0) begin : g_bad_slot
      $error("ADDR_BYTES must be a multiple of SLOT_BYTES");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("mode word layout needs DATA_W of 32");
   end
   if (SLOT_BYTES * 8 > DATA_W || (1 << PTR_W) < ADDR_BYTES) begin : g_bad_ptr
      $error("slot or pointer width too small");
   end

   logic [DATA_W-1:0]       mode_q;
   logic [PTR_W-1:0]        ptr_q;
   logic [ADDR_BYTES*8-1:0] station_q;
   logic                    cmp_last, cmp_eq, cmp_ones, cmp_grp;

   daf_regs #(.ADDR_BYTES(ADDR_BYTES), .SLOT_BYTES(SLOT_BYTES),
              .DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_q(mode_q),
      .ptr_q(ptr_q), .station_q(station_q)
   );

   daf_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
      .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
      .byte_data(byte_data), .station(station_q), .last(cmp_last),
      .eq_n(cmp_eq), .ones_n(cmp_ones), .grp_n(cmp_grp)
   );

   daf_decide #(.DATA_W(DATA_W)) u_decide (
      .clk(clk), .rst_n(rst_n), .last(cmp_last), .eq(cmp_eq),
      .ones(cmp_ones), .grp(cmp_grp), .mode(mode_q),
      .res_vld(res_vld), .res_accept(res_accept)
   );
endmodule

// File: rtl/daf_chk.sv
module daf_chk #(
   parameter int ADDR_BYTES = 6,
   parameter int PTR_W      = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    reg_wr,
   input logic [1:0]              reg_sel,
   input logic [PTR_W-1:0]        ptr_q,
   input logic [31:0]             mode_q,
   input logic [ADDR_BYTES*8-1:0] station_q,
   input logic                    cmp_last,
   input logic                    cmp_ones,
   input logic                    res_vld,
   input logic                    res_accept
);
   logic bad_ptr;
   assign bad_ptr = ptr_q[0] || (ptr_q >= PTR_W'(ADDR_BYTES));

   AST_VLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_last |=> res_vld); // R9
   AST_NO_STRAY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_last |=> !res_vld); // R9
   AST_ACC_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      res_accept |-> res_vld); // R9
   AST_DISABLED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_last && !mode_q[31]) |=> !res_accept); // R4
   AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_last && cmp_ones && mode_q[31] && mode_q[30]) |=> res_accept); // R5
   AST_BAD_PTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 2'd2 && bad_ptr) |=> $stable(station_q)); // R3
endmodule

bind dest_addr_filter daf_chk #(.ADDR_BYTES(ADDR_BYTES), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
   .ptr_q(ptr_q), .mode_q(mode_q), .station_q(station_q),
   .cmp_last(cmp_last), .cmp_ones(cmp_ones),
   .res_vld(res_vld), .res_accept(res_accept)
);

// File: tb/dest_addr_filter_tb.sv
`timescale 1ns/1ps
module dest_addr_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sof = 1'b0, byte_vld = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        res_vld, res_accept;
   int          n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   dest_addr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sof(sof),
      .byte_vld(byte_vld), .byte_data(byte_data),
      .res_vld(res_vld), .res_accept(res_accept)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_sel = 2'd3;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] d);
      @(negedge clk);
      reg_sel = sel;
      #1 d = reg_rdata;
      reg_sel = 2'd3;
   endtask

   task automatic load_station(input logic [47:0] st);
      for (int s = 0; s < 3; s++) begin
         wr(2'd1, 32'(2 * s));
         wr(2'd2, {16'h0, st[s*16 +: 16]});
      end
   endtask

   function automatic logic exp_acc(input logic [31:0] m, input logic [47:0] d, input logic [47:0] st);
      logic bc, mc, uc;
      bc = (d == 48'hFFFF_FFFF_FFFF);
      mc = d[0] && !bc;
      uc = !d[0];
      return m[31] && ((bc && m[30]) || (mc && m[29]) || (uc && m[28]) || ((d == st) && m[27]));
   endfunction

   // Sends six bytes from sof; checks the pulse timing and returns accept.
   task automatic frame(input logic [47:0] d, output logic acc);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i == 5) chk({31'h0, res_vld}, 32'h0, "R9 early valid");
         sof = (i == 0); byte_vld = 1'b1; byte_data = d[i*8 +: 8];
      end
      @(negedge clk);
      sof = 1'b0; byte_vld = 1'b0;
      chk({31'h0, res_vld}, 32'h1, "R9 valid one cycle after sixth byte");
      acc = res_accept;
      @(negedge clk);
      chk({30'h0, res_vld, res_accept}, 32'h0, "R9 single-cycle pulse");
   endtask

   logic [47:0] sta = 48'h55_44_33_22_11_02;
   logic [47:0] dst [6];

   initial begin
      logic [31:0] r;
      logic        a;
      dst[0] = 48'hFFFF_FFFF_FFFF;
      dst[1] = 48'h01_00_00_5E_00_01;
      dst[2] = sta;
      dst[3] = 48'h56_44_33_22_11_02;
      dst[4] = 48'hFEFF_FFFF_FFFF;
      dst[5] = 48'h00_00_00_00_00_00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1, R11 reset state
      rd(2'd0, r); chk(r, 32'h0, "R1 mode reset");
      for (int s = 0; s < 3; s++) begin
         wr(2'd1, 32'(2 * s)); rd(2'd2, r); chk(r, 32'h0, "R11 station reset");
      end
      // R1 mode written while disabled reads back
      wr(2'd0, 32'h7800_0000); rd(2'd0, r); chk(r, 32'h7800_0000, "R1 mode readback");
      // R2 station load and readback layout
      load_station(sta);
      for (int s = 0; s < 3; s++) begin
         wr(2'd1, 32'(2 * s)); rd(2'd2, r);
         chk(r, {16'h0, sta[s*16 +: 16]}, "R2 slot readback");
      end
      // R3 odd and out-of-range pointer values
      for (int p = 1; p < 8; p += 2) begin
         wr(2'd1, 32'(p)); wr(2'd2, 32'h0000_ABCD);
         rd(2'd2, r); chk(r, 32'h0, "R3 bad pointer read");
      end
      wr(2'd1, 32'd6); wr(2'd2, 32'h0000_ABCD);
      rd(2'd2, r); chk(r, 32'h0, "R3 pointer 6 read");
      for (int s = 0; s < 3; s++) begin
         wr(2'd1, 32'(2 * s)); rd(2'd2, r);
         chk(r, {16'h0, sta[s*16 +: 16]}, "R3 station unchanged");
      end
      // R4-R8 sweep of all mode bit combinations
      for (int m = 0; m < 32; m++) begin
         wr(2'd0, {m[4:0], 27'h0});
         for (int k = 0; k < 6; k++) begin
            frame(dst[k], a);
            chk({31'h0, a}, {31'h0, exp_acc({m[4:0], 27'h0}, dst[k], sta)},
                "R4 R5 R6 R7 R8 accept decision");
         end
      end
      // R8 broadcast plus perfect match
      wr(2'd0, 32'hC800_0000);
      frame(dst[1], a); chk({31'h0, a}, 32'h0, "R8 other multicast rejected");
      frame(dst[2], a); chk({31'h0, a}, 32'h1, "R8 station accepted");
      frame(dst[0], a); chk({31'h0, a}, 32'h1, "R8 broadcast accepted");
      // R10 sof restarts mid-frame
      wr(2'd0, 32'h8800_0000);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); sof = (i == 0); byte_vld = 1'b1; byte_data = dst[3][i*8 +: 8];
      end
      frame(sta, a); chk({31'h0, a}, 32'h1, "R10 restart compares new frame");
      // R10 extra bytes after sixth give no result
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); sof = (i == 0); byte_vld = 1'b1; byte_data = sta[(i % 6)*8 +: 8];
      end
      @(negedge clk); byte_vld = 1'b0; sof = 1'b0;
      chk({31'h0, res_vld}, 32'h0, "R10 trailing bytes ignored");
      @(negedge clk); chk({31'h0, res_vld}, 32'h0, "R10 still quiet");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule